// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarms

This block keeps wall-clock time and date from a 2 Hz strobe. A half-second phase bit flips on every strobe, and the seconds count steps on every second strobe. A carry ripples from seconds through minutes, hours, day of month and month to a two-digit year. The day count knows the length of each month, and February gains a twenty-ninth day in leap years. All counters are plain binary. A small register port lets software load the calendar, program two alarm comparators and choose a periodic interrupt rate. Every calendar field, plus the phase bit, is visible on output ports at all times.

The periodic interrupt can follow every strobe, every second, every minute or every hour. The two alarms compare different sets of fields. The first alarm checks day of month, hour and minute, so it repeats every month on that date. The second alarm also checks the month, so it fires once a year. Each alarm pulses at the instant its minute begins. All interrupts are single-cycle pulses, raised in the clock cycle that follows the edge that took the strobe.

Top module: `cal_rtc`

## Requirements
- R1: After reset the clock reads year 0, month 1, day 1, 00:00:00. The phase bit is 0, the periodic source and both alarms are disabled, and every interrupt is low.
- R2: The phase bit toggles on each accepted `tick`. Seconds advance only on a tick that finds the phase bit at 1. Seconds wrap from 59 to 0, and that wrap advances the minute.
- R3: A minute wrap from 59 to 0 advances the hour. An hour wrap from 23 to 0 advances the day.
- R4: After the last day of a month the day returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days. Every other month except February has 31 days.
- R5: February has 29 days when the year is divisible by 4, year 0 included, and 28 days otherwise.
- R6: A month wrap from 12 to 1 advances the year. Year 99 wraps to 0.
- R7: A write with `wr_sel` 0, 1, 2, 3 or 4 loads minute, hour, day, month or year from the low bits of `wr_data`. The same write clears the seconds and the phase bit. When a write and a tick share a cycle, the write is taken and the tick is dropped.
- R8: A write with `wr_sel` 14 sets the periodic source. Bit 2 is the enable. Bits 1:0 pick the rate: 0 for every tick, 1 for every seconds step, 2 for every minute wrap, 3 for every hour wrap. `per_irq` pulses for one cycle after the edge that took the qualifying tick.
- R9: Alarm A is loaded by `wr_sel` 5 (minute), 6 (hour) and 7 (day), and enabled by `wr_sel` 8 bit 0. When enabled, it pulses `alm0_irq` on the tick that makes the seconds read 0 and makes minute, hour and day match. The month plays no part.
- R10: Alarm B is loaded by `wr_sel` 9 (minute), 10 (hour), 11 (day) and 12 (month), and enabled by `wr_sel` 13 bit 0. It pulses `alm1_irq` the same way, but only when all four fields match.
- R11: A disabled alarm never pulses. Writes never raise an alarm, even when they load time values equal to the alarm fields. A write with `wr_sel` 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 2 Hz strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | 7 | Write data |
| sec_o | output | 6 | Seconds, 0 to 59 |
| min_o | output | 6 | Minutes, 0 to 59 |
| hour_o | output | 5 | Hours, 0 to 23 |
| day_o | output | 5 | Day of month, 1 to 31 |
| month_o | output | 4 | Month, 1 to 12 |
| year_o | output | 7 | Year, 0 to 99 |
| half_o | output | 1 | Half-second phase bit |
| per_irq | output | 1 | Periodic interrupt pulse |
| alm0_irq | output | 1 | Alarm A pulse |
| alm1_irq | output | 1 | Alarm B pulse |

## Verification
The hardest conditions to reach from the ports are the deep carries: the end of February in leap and non-leap years, the end of a 30-day month, and the wrap of the year. Reaching them by counting would take months of simulated ticks. The bench instead loads the calendar to one minute before the boundary and then applies 120 ticks, one every other clock. The alarm tests use the same preload, and they also load time values equal to the alarm fields directly, to show that writes alone never raise an alarm.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int SEL_W   = 4;
  localparam int DATA_W  = 7;
  localparam int CFG_W   = 3;

  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int DAY_W   = 5;
  localparam int MON_W   = 4;
  localparam int YEAR_W  = 7;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;
  localparam int MON_LAST  = 12;
  localparam int YEAR_LAST = 99;
  localparam int LEAP_STEP = 4;

  // register select codes
  localparam logic [SEL_W-1:0] SEL_MIN   = 4'd0;
  localparam logic [SEL_W-1:0] SEL_HOUR  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_DAY   = 4'd2;
  localparam logic [SEL_W-1:0] SEL_MON   = 4'd3;
  localparam logic [SEL_W-1:0] SEL_YEAR  = 4'd4;
  localparam logic [SEL_W-1:0] SEL_A_BASE = 4'd5;
  localparam logic [SEL_W-1:0] SEL_A_EN   = 4'd8;
  localparam logic [SEL_W-1:0] SEL_B_BASE = 4'd9;
  localparam logic [SEL_W-1:0] SEL_B_EN   = 4'd13;
  localparam logic [SEL_W-1:0] SEL_PER    = 4'd14;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_t;

  typedef enum logic [1:0] {
    PER_HALF = 2'd0,
    PER_SEC  = 2'd1,
    PER_MIN  = 2'd2,
    PER_HOUR = 2'd3
  } per_rate_e;

  localparam cal_t CAL_RESET = '{year: '0, month: 4'd1, day: 5'd1,
                                 hour: '0, min: '0, sec: '0};

  function automatic logic leap_year(input logic [YEAR_W-1:0] y);
    return (int'(y) % LEAP_STEP) == 0;
  endfunction

  function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                 input logic [YEAR_W-1:0] y);
    case (m)
      4'd2:                   return leap_year(y) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output cal_t              now,
  output logic              half,
  output logic              ev_half,
  output logic              ev_sec,
  output logic              ev_min,
  output logic              ev_hour
);

  logic time_wr;
  logic c_sec, c_min, c_hour, c_day, c_mon, c_year;
  logic ev_day;
  logic [DAY_W-1:0] last_day;

  always_comb begin
    time_wr  = wr_en && (wr_sel <= SEL_YEAR);
    last_day = month_len(now.month, now.year);
    c_sec    = tick && half;
    c_min    = c_sec  && (now.sec   >= SEC_W'(SEC_LAST));
    c_hour   = c_min  && (now.min   >= MIN_W'(MIN_LAST));
    c_day    = c_hour && (now.hour  >= HOUR_W'(HOUR_LAST));
    c_mon    = c_day  && (now.day   >= last_day);
    c_year   = c_mon  && (now.month >= MON_W'(MON_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now     <= CAL_RESET;
      half    <= 1'b0;
      ev_half <= 1'b0;
      ev_sec  <= 1'b0;
      ev_min  <= 1'b0;
      ev_hour <= 1'b0;
      ev_day  <= 1'b0;
    end else begin
      ev_half <= 1'b0;
      ev_sec  <= 1'b0;
      ev_min  <= 1'b0;
      ev_hour <= 1'b0;
      ev_day  <= 1'b0;
      if (time_wr) begin
        half    <= 1'b0;
        now.sec <= '0;
        case (wr_sel)
          SEL_MIN:  now.min   <= wr_data[MIN_W-1:0];
          SEL_HOUR: now.hour  <= wr_data[HOUR_W-1:0];
          SEL_DAY:  now.day   <= wr_data[DAY_W-1:0];
          SEL_MON:  now.month <= wr_data[MON_W-1:0];
          default:  now.year  <= wr_data[YEAR_W-1:0];
        endcase
      end else if (tick) begin
        half    <= !half;
        ev_half <= 1'b1;
        ev_sec  <= c_sec;
        ev_min  <= c_min;
        ev_hour <= c_hour;
        ev_day  <= c_day;
        if (c_sec)
          now.sec <= c_min ? '0 : now.sec + SEC_W'(1);
        if (c_min)
          now.min <= c_hour ? '0 : now.min + MIN_W'(1);
        if (c_hour)
          now.hour <= c_day ? '0 : now.hour + HOUR_W'(1);
        if (c_day)
          now.day <= c_mon ? DAY_W'(1) : now.day + DAY_W'(1);
        if (c_mon)
          now.month <= c_year ? MON_W'(1) : now.month + MON_W'(1);
        if (c_year)
          now.year <= (now.year >= YEAR_W'(YEAR_LAST)) ? '0 : now.year + YEAR_W'(1);
      end
    end
  end

  AST_MIN_AT_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_min |-> (now.sec == '0)); // R2
  AST_SEC_LEAVES_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sec |-> !half); // R2
  AST_DAY_AT_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day |-> (now.hour == '0 && now.min == '0)); // R3
  AST_NEW_MONTH_DAY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_day && now.month != $past(now.month)) |-> (now.day == DAY_W'(1))); // R4
  AST_WRITE_CLEARS_SUBMIN: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (now.sec == '0 && !half)); // R7

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter bit               HAS_MONTH = 1'b0,
  parameter logic [SEL_W-1:0] SEL_BASE  = SEL_A_BASE,
  parameter logic [SEL_W-1:0] SEL_EN    = SEL_A_EN
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [MIN_W-1:0]  wr_data,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [MON_W-1:0]  cur_month,
  input  logic              ev_min,
  output logic              irq
);

  localparam logic [SEL_W-1:0] SEL_F_MIN  = SEL_BASE;
  localparam logic [SEL_W-1:0] SEL_F_HOUR = SEL_BASE + SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_F_DAY  = SEL_BASE + SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_F_MON  = SEL_BASE + SEL_W'(3);

  logic [MIN_W-1:0]  a_min;
  logic [HOUR_W-1:0] a_hour;
  logic [DAY_W-1:0]  a_day;
  logic [MON_W-1:0]  a_mon;
  logic              en;
  logic              month_ok;
  logic              hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_min  <= '0;
      a_hour <= '0;
      a_day  <= '0;
      a_mon  <= '0;
      en     <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel == SEL_F_MIN)  a_min  <= wr_data;
      if (wr_sel == SEL_F_HOUR) a_hour <= wr_data[HOUR_W-1:0];
      if (wr_sel == SEL_F_DAY)  a_day  <= wr_data[DAY_W-1:0];
      if (HAS_MONTH && wr_sel == SEL_F_MON) a_mon <= wr_data[MON_W-1:0];
      if (wr_sel == SEL_EN)     en     <= wr_data[0];
    end
  end

  // a month-less alarm treats the month as always matching
  assign month_ok = HAS_MONTH ? (cur_month == a_mon) : 1'b1;
  assign hit      = (cur_min == a_min) && (cur_hour == a_hour) &&
                    (cur_day == a_day) && month_ok;
  assign irq      = en && ev_min && hit;

  // covers both alarm variants (R9 and R10)
  AST_ALARM_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CFG_W-1:0] wr_cfg,
  input  logic             ev_half,
  input  logic             ev_sec,
  input  logic             ev_min,
  input  logic             ev_hour,
  output logic             per_irq
);

  per_rate_e rate;
  logic      en;
  logic      src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate <= PER_HALF;
      en   <= 1'b0;
    end else if (wr_en && wr_sel == SEL_PER) begin
      rate <= per_rate_e'(wr_cfg[1:0]);
      en   <= wr_cfg[2];
    end
  end

  always_comb begin
    case (rate)
      PER_HALF: src = ev_half;
      PER_SEC:  src = ev_sec;
      PER_MIN:  src = ev_min;
      default:  src = ev_hour;
    endcase
  end

  assign per_irq = en && src;

  AST_SLOW_RATE_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (per_irq && rate != PER_HALF) |-> (ev_sec && ev_half)); // R8

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [DAY_W-1:0]  day_o,
  output logic [MON_W-1:0]  month_o,
  output logic [YEAR_W-1:0] year_o,
  output logic              half_o,
  output logic              per_irq,
  output logic              alm0_irq,
  output logic              alm1_irq
);

  cal_t now;
  logic ev_half, ev_sec, ev_min, ev_hour;

  rtc_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .now     (now),
    .half    (half_o),
    .ev_half (ev_half),
    .ev_sec  (ev_sec),
    .ev_min  (ev_min),
    .ev_hour (ev_hour)
  );

  rtc_periodic u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_cfg  (wr_data[CFG_W-1:0]),
    .ev_half (ev_half),
    .ev_sec  (ev_sec),
    .ev_min  (ev_min),
    .ev_hour (ev_hour),
    .per_irq (per_irq)
  );

  rtc_alarm #(.HAS_MONTH(1'b0), .SEL_BASE(SEL_A_BASE), .SEL_EN(SEL_A_EN)) u_alm_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data[MIN_W-1:0]),
    .cur_min   (now.min),
    .cur_hour  (now.hour),
    .cur_day   (now.day),
    .cur_month (now.month),
    .ev_min    (ev_min),
    .irq       (alm0_irq)
  );

  rtc_alarm #(.HAS_MONTH(1'b1), .SEL_BASE(SEL_B_BASE), .SEL_EN(SEL_B_EN)) u_alm_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data[MIN_W-1:0]),
    .cur_min   (now.min),
    .cur_hour  (now.hour),
    .cur_day   (now.day),
    .cur_month (now.month),
    .ev_min    (ev_min),
    .irq       (alm1_irq)
  );

  assign sec_o   = now.sec;
  assign min_o   = now.min;
  assign hour_o  = now.hour;
  assign day_o   = now.day;
  assign month_o = now.month;
  assign year_o  = now.year;

  AST_IRQ_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (per_irq || alm0_irq || alm1_irq) |-> $past(tick)); // R8
  AST_ALARM_AT_MINUTE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (alm0_irq || alm1_irq) |-> (sec_o == '0 && !half_o)); // R10

endmodule

// File: tb/sim_cal_rtc.sv
module sim_cal_rtc;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam int MINUTE_TICKS = 120;

  // select codes as listed in the requirements
  localparam int W_MIN = 0, W_HOUR = 1, W_DAY = 2, W_MON = 3, W_YEAR = 4;
  localparam int W_A_MIN = 5, W_A_HOUR = 6, W_A_DAY = 7, W_A_EN = 8;
  localparam int W_B_MIN = 9, W_B_HOUR = 10, W_B_DAY = 11, W_B_MON = 12, W_B_EN = 13;
  localparam int W_PER = 14, W_NONE = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [6:0] wr_data = '0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hour_o, day_o;
  logic [3:0] month_o;
  logic [6:0] year_o;
  logic       half_o, per_irq, alm0_irq, alm1_irq;

  int n_vec = 0;
  int n_bad = 0;
  int cnt_per = 0, cnt_a0 = 0, cnt_a1 = 0, cnt_spur = 0;
  bit done = 1'b0;

  cal_rtc u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .day_o(day_o), .month_o(month_o), .year_o(year_o), .half_o(half_o),
    .per_irq(per_irq), .alm0_irq(alm0_irq), .alm1_irq(alm1_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    cnt_per += int'(per_irq);
    cnt_a0  += int'(alm0_irq);
    cnt_a1  += int'(alm1_irq);
    if (alm0_irq || alm1_irq) check("R9", "alarm seconds", int'(sec_o), 0);
  endtask

  task automatic run_ticks(input int n);
    cnt_per = 0; cnt_a0 = 0; cnt_a1 = 0;
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 7'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (alm0_irq || alm1_irq) cnt_spur++;
  endtask

  task automatic set_time(input int y, input int m, input int d, input int h, input int mi);
    wr(W_YEAR, y); wr(W_MON, m); wr(W_DAY, d); wr(W_HOUR, h); wr(W_MIN, mi);
  endtask

  task automatic chk_time(input string req, input int y, input int m, input int d,
                          input int h, input int mi, input int s);
    check(req, "year",   int'(year_o),  y);
    check(req, "month",  int'(month_o), m);
    check(req, "day",    int'(day_o),   d);
    check(req, "hour",   int'(hour_o),  h);
    check(req, "minute", int'(min_o),   mi);
    check(req, "second", int'(sec_o),   s);
  endtask

  // one minute from hh:mm to the next minute boundary
  task automatic roll_minute(input string req, input int y, input int m, input int d,
                             input int h, input int mi,
                             input int ey, input int em, input int ed, input int eh, input int emi);
    set_time(y, m, d, h, mi);
    run_ticks(MINUTE_TICKS);
    chk_time(req, ey, em, ed, eh, emi, 0);
  endtask

  task automatic t_reset();
    chk_time("R1", 0, 1, 1, 0, 0, 0);
    check("R1", "phase", int'(half_o), 0);
    check("R1", "irqs", int'({per_irq, alm0_irq, alm1_irq}), 0);
    run_ticks(4);
    check("R1", "periodic off", cnt_per, 0);
    check("R1", "alarms off", cnt_a0 + cnt_a1, 0);
  endtask

  task automatic t_seconds();
    wr(W_PER, 3'b100);
    wr(W_MIN, 0);
    do_tick();
    check("R2", "phase after 1 tick", int'(half_o), 1);
    check("R2", "sec after 1 tick", int'(sec_o), 0);
    check("R8", "per every tick", cnt_per, 1);
    do_tick();
    check("R2", "phase after 2 ticks", int'(half_o), 0);
    check("R2", "sec after 2 ticks", int'(sec_o), 1);
    wr(W_PER, 3'b101);
    run_ticks(10);
    check("R8", "per per second", cnt_per, 5);
    check("R2", "sec after 12 ticks", int'(sec_o), 6);
    wr(W_PER, 3'b001);
    run_ticks(4);
    check("R8", "per disabled", cnt_per, 0);
  endtask

  task automatic t_minute_hour();
    wr(W_PER, 3'b110);
    roll_minute("R2", 0, 1, 1, 5, 58, 0, 1, 1, 5, 59);
    check("R8", "per on minute", cnt_per, 1);
    roll_minute("R3", 0, 1, 1, 5, 59, 0, 1, 1, 6, 0);
    wr(W_PER, 3'b111);
    roll_minute("R8", 0, 1, 1, 6, 58, 0, 1, 1, 6, 59);
    check("R8", "no hour irq mid-hour", cnt_per, 0);
    roll_minute("R3", 0, 1, 1, 6, 59, 0, 1, 1, 7, 0);
    check("R8", "per on hour", cnt_per, 1);
    roll_minute("R3", 1, 4, 15, 23, 59, 1, 4, 16, 0, 0);
  endtask

  task automatic t_months();
    roll_minute("R4", 1, 4, 30, 23, 59, 1, 5, 1, 0, 0);
    roll_minute("R4", 1, 1, 30, 23, 59, 1, 1, 31, 0, 0);
    roll_minute("R4", 1, 1, 31, 23, 59, 1, 2, 1, 0, 0);
    roll_minute("R4", 1, 11, 30, 23, 59, 1, 12, 1, 0, 0);
    roll_minute("R4", 1, 8, 31, 23, 59, 1, 9, 1, 0, 0);
  endtask

  task automatic t_leap();
    roll_minute("R5", 4, 2, 28, 23, 59, 4, 2, 29, 0, 0);
    roll_minute("R5", 4, 2, 29, 23, 59, 4, 3, 1, 0, 0);
    roll_minute("R5", 5, 2, 28, 23, 59, 5, 3, 1, 0, 0);
    roll_minute("R5", 0, 2, 28, 23, 59, 0, 2, 29, 0, 0);
  endtask

  task automatic t_year();
    roll_minute("R6", 7, 12, 31, 23, 59, 8, 1, 1, 0, 0);
    roll_minute("R6", 99, 12, 31, 23, 59, 0, 1, 1, 0, 0);
  endtask

  task automatic t_write();
    set_time(3, 3, 3, 3, 10);
    do_tick();
    check("R7", "phase before collision", int'(half_o), 1);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(W_HOUR); wr_data = 7'd9; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk_time("R7", 3, 3, 3, 9, 10, 0);
    check("R7", "phase after collision", int'(half_o), 0);
    run_ticks(11);
    check("R7", "sec running", int'(sec_o), 5);
    wr(W_DAY, 17);
    chk_time("R7", 3, 3, 17, 9, 10, 0);
    check("R7", "phase cleared", int'(half_o), 0);
  endtask

  task automatic t_alarm_a();
    wr(W_A_MIN, 0); wr(W_A_HOUR, 10); wr(W_A_DAY, 3); wr(W_A_EN, 1);
    roll_minute("R9", 2, 6, 3, 9, 59, 2, 6, 3, 10, 0);
    check("R9", "alarm A fires", cnt_a0, 1);
    check("R9", "alarm B quiet", cnt_a1, 0);
    roll_minute("R9", 2, 9, 3, 9, 59, 2, 9, 3, 10, 0);
    check("R9", "alarm A ignores month", cnt_a0, 1);
    roll_minute("R9", 2, 9, 4, 9, 59, 2, 9, 4, 10, 0);
    check("R9", "alarm A day mismatch", cnt_a0, 0);
  endtask

  task automatic t_alarm_b();
    wr(W_B_MIN, 30); wr(W_B_HOUR, 12); wr(W_B_DAY, 4); wr(W_B_MON, 7); wr(W_B_EN, 1);
    roll_minute("R10", 2, 6, 4, 12, 29, 2, 6, 4, 12, 30);
    check("R10", "alarm B month mismatch", cnt_a1, 0);
    roll_minute("R10", 2, 7, 4, 12, 29, 2, 7, 4, 12, 30);
    check("R10", "alarm B fires", cnt_a1, 1);
    check("R10", "alarm A quiet", cnt_a0, 0);
  endtask

  task automatic t_ignored();
    wr(W_A_EN, 0);
    roll_minute("R11", 2, 6, 3, 9, 59, 2, 6, 3, 10, 0);
    check("R11", "disabled alarm A", cnt_a0, 0);
    cnt_spur = 0;
    set_time(2, 7, 4, 12, 30);
    wr(W_A_EN, 1);
    set_time(2, 6, 3, 10, 0);
    check("R11", "writes raise no alarm", cnt_spur, 0);
    wr(W_NONE, 7'h55);
    chk_time("R11", 2, 6, 3, 10, 0, 0);
    run_ticks(6);
    check("R11", "select 15 left alarms", cnt_a0 + cnt_a1, 0);
    check("R11", "select 15 left periodic", cnt_per, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_minute_hour();
    t_months();
    t_leap();
    t_year();
    t_write();
    t_alarm_a();
    t_alarm_b();
    t_ignored();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG_CYCLES);
      finish_run();
    end
  end

endmodule